// File: doc/BRIEF.md
# SATA BIST Pattern Generator

This block produces a loopback characterization stream for a serial link. It emits one Dword per clock. Each Dword is 32 bits of data plus a 4-bit mask that marks which bytes are control (K) characters. A downstream 8b/10b encoder consumes the stream.

A 2-bit select input chooses one of four patterns:

- three fixed patterns that repeat without end;
- a counting pattern that increments once per Dword.

Generation runs only while the enable input is high. While it is low, an idle Dword is produced with its valid flag cleared. Alongside each Dword the block passes two controls to the encoder. One is a disparity-error injection request, which follows a live force input. The other is a polarity-invert flag, which swaps the transmit differential pair.

Byte lane 0 (data bits 7:0) is the first character on the line, and lane 3 (bits 31:24) is the last. All outputs are registered. Each output Dword reflects the inputs sampled at the previous rising clock edge.

Top module: `sata_bist_gen`

## Requirements
- R1: While reset is high and on the first edge after it, `bist_valid`, `bist_data`, `bist_kmask`, `bist_disp_err` and `bist_invert` are all 0.
- R2: With select 00 and enable high, the next Dword is valid with data B5B5B5B5h (D21.5 in every lane) and mask 0000b.
- R3: With select 01 and enable high, the next Dword is valid with data 78787878h (D24.3 in every lane) and mask 0000b.
- R4: With select 10 and enable high, the next Dword is valid with data BC4A4A4Ah and mask 1000b. Lanes 0 to 2 carry D10.2 (4Ah) and lane 3 carries K28.5 (BCh).
- R5: With select 11 and enable high on consecutive cycles, each Dword carries the previous count plus one in its low CNT_W bits. The upper data bits and the mask are 0.
- R6: The count restarts at 0 on the first counting Dword after the enable was low or the select value changed.
- R7: The count wraps from 2^CNT_W-1 to 0 and continues.
- R8: When enable is low, the next Dword has valid 0, data 0 and mask 0.
- R9: `bist_disp_err` is 1 exactly when the Dword is valid and the force input was high in the cycle that produced it.
- R10: `bist_invert` equals the invert input of the previous cycle, whether or not generation is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Pattern generation enable |
| pat_sel | input | 2 | Pattern select: 00 D21.5, 01 D24.3, 10 three D10.2 then K28.5, 11 counting |
| force_disp | input | 1 | Request disparity-error injection while high |
| tx_invert | input | 1 | Request transmit polarity swap |
| bist_valid | output | 1 | Dword carries pattern data |
| bist_data | output | 32 | Pattern Dword, lane 0 first on the line |
| bist_kmask | output | 4 | Per-lane control-character flags |
| bist_disp_err | output | 1 | Disparity-error injection request for this Dword |
| bist_invert | output | 1 | Polarity-invert flag to the encoder |

## Verification
The bench builds the block with CNT_W = 8. With that width the counting pattern wraps after 256 Dwords, so the wrap boundary falls inside a short run. The count restarts are driven by dropping the enable, by switching the select away and back, and by the wrap run itself. The fixed patterns are interleaved with force and invert toggling, so that both controls are seen on valid and on idle Dwords.

// File: rtl/sata_bist_pkg.sv
package sata_bist_pkg;

    localparam int LANES     = 4;
    localparam int LANE_BITS = 8;
    localparam int DW_BITS   = LANES * LANE_BITS;

    typedef enum logic [1:0] {
        PAT_D21_5  = 2'b00,
        PAT_D24_3  = 2'b01,
        PAT_MIXED  = 2'b10,
        PAT_COUNT  = 2'b11
    } pat_sel_e;

    localparam logic [LANE_BITS-1:0] CHR_D21_5 = 8'hB5;
    localparam logic [LANE_BITS-1:0] CHR_D24_3 = 8'h78;
    localparam logic [LANE_BITS-1:0] CHR_D10_2 = 8'h4A;
    localparam logic [LANE_BITS-1:0] CHR_K28_5 = 8'hBC;

    // Position of the control character inside the mixed group
    localparam int MIXED_K_LANE = LANES - 1;

    typedef struct packed {
        logic                 is_k;
        logic [LANE_BITS-1:0] code;
    } lane_char_t;

    typedef struct packed {
        logic               valid;
        logic [DW_BITS-1:0] data;
        logic [LANES-1:0]   kmask;
        logic               disp_err;
        logic               invert;
    } bist_word_t;

    localparam bist_word_t WORD_IDLE = '{
        valid: 1'b0, data: '0, kmask: '0, disp_err: 1'b0, invert: 1'b0
    };

    // Character carried by one lane for a fixed pattern
    function automatic lane_char_t fixed_lane_char(pat_sel_e sel, int unsigned lane);
        lane_char_t c;
        c.is_k = 1'b0;
        c.code = '0;
        case (sel)
            PAT_D21_5: c.code = CHR_D21_5;
            PAT_D24_3: c.code = CHR_D24_3;
            PAT_MIXED: begin
                if (lane == MIXED_K_LANE) begin
                    c.is_k = 1'b1;
                    c.code = CHR_K28_5;
                end else begin
                    c.code = CHR_D10_2;
                end
            end
            default: c.code = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_fixed(pat_sel_e sel);
        return sel != PAT_COUNT;
    endfunction

endpackage

// File: rtl/sata_bist_fixed_gen.sv
module sata_bist_fixed_gen
    import sata_bist_pkg::*;
(
    input  pat_sel_e                 sel,
    output logic [DW_BITS-1:0]       fixed_data,
    output logic [LANES-1:0]         fixed_kmask
);

    lane_char_t lane_chr [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_chr[g] = fixed_lane_char(sel, g);
        end
        assign fixed_data[g*LANE_BITS +: LANE_BITS] = lane_chr[g].code;
        assign fixed_kmask[g]                       = lane_chr[g].is_k;
    end

endmodule

// File: rtl/sata_bist_count_gen.sv
module sata_bist_count_gen
    import sata_bist_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  pat_sel_e         sel,
    output logic [CNT_W-1:0] cnt_value
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             prev_en;
    pat_sel_e         prev_sel;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             advance;

    // Start again from zero after an idle gap or a pattern switch
    always_comb begin
        restart   = !prev_en || (prev_sel != sel);
        cnt_value = restart ? '0 : cnt_q;
        advance   = gen_en && (sel == PAT_COUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en  <= 1'b0;
            prev_sel <= PAT_D21_5;
            cnt_q    <= '0;
        end else begin
            prev_en  <= gen_en;
            prev_sel <= sel;
            if (advance) begin
                cnt_q <= cnt_value + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/sata_bist_out_stage.sv
module sata_bist_out_stage
    import sata_bist_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gen_en,
    input  pat_sel_e           sel,
    input  logic               force_disp,
    input  logic               tx_invert,
    input  logic [DW_BITS-1:0] fixed_data,
    input  logic [LANES-1:0]   fixed_kmask,
    input  logic [CNT_W-1:0]   cnt_value,
    output bist_word_t         word_q
);

    logic [DW_BITS-1:0] cnt_data;
    bist_word_t         word_d;

    if (CNT_W < DW_BITS) begin : g_pad
        assign cnt_data = {{(DW_BITS-CNT_W){1'b0}}, cnt_value};
    end else begin : g_full
        assign cnt_data = cnt_value[DW_BITS-1:0];
    end

    always_comb begin
        word_d        = WORD_IDLE;
        word_d.invert = tx_invert;
        if (gen_en) begin
            word_d.valid    = 1'b1;
            word_d.disp_err = force_disp;
            if (is_fixed(sel)) begin
                word_d.data  = fixed_data;
                word_d.kmask = fixed_kmask;
            end else begin
                word_d.data  = cnt_data;
                word_d.kmask = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= WORD_IDLE;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/sata_bist_gen.sv
module sata_bist_gen
    import sata_bist_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        gen_en,
    input  logic [1:0]  pat_sel,
    input  logic        force_disp,
    input  logic        tx_invert,
    output logic        bist_valid,
    output logic [31:0] bist_data,
    output logic [3:0]  bist_kmask,
    output logic        bist_disp_err,
    output logic        bist_invert
);

    pat_sel_e           sel;
    logic [DW_BITS-1:0] fixed_data;
    logic [LANES-1:0]   fixed_kmask;
    logic [CNT_W-1:0]   cnt_value;
    bist_word_t         word_q;

    assign sel = pat_sel_e'(pat_sel);

    sata_bist_fixed_gen i_fixed (
        .sel         (sel),
        .fixed_data  (fixed_data),
        .fixed_kmask (fixed_kmask)
    );

    sata_bist_count_gen #(.CNT_W(CNT_W)) i_count (
        .clk       (clk),
        .rst       (rst),
        .gen_en    (gen_en),
        .sel       (sel),
        .cnt_value (cnt_value)
    );

    sata_bist_out_stage #(.CNT_W(CNT_W)) i_out (
        .clk         (clk),
        .rst         (rst),
        .gen_en      (gen_en),
        .sel         (sel),
        .force_disp  (force_disp),
        .tx_invert   (tx_invert),
        .fixed_data  (fixed_data),
        .fixed_kmask (fixed_kmask),
        .cnt_value   (cnt_value),
        .word_q      (word_q)
    );

    assign bist_valid    = word_q.valid;
    assign bist_data     = word_q.data;
    assign bist_kmask    = word_q.kmask;
    assign bist_disp_err = word_q.disp_err;
    assign bist_invert   = word_q.invert;

endmodule

// File: rtl/sata_bist_gen_chk.sv
module sata_bist_gen_chk #(
    parameter int CNT_W = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        gen_en,
    input logic [1:0]  pat_sel,
    input logic        force_disp,
    input logic        tx_invert,
    input logic        bist_valid,
    input logic [31:0] bist_data,
    input logic [3:0]  bist_kmask,
    input logic        bist_disp_err,
    input logic        bist_invert
);

    logic armed1;
    logic armed2;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed1 <= 1'b0;
            armed2 <= 1'b0;
        end else begin
            armed1 <= 1'b1;
            armed2 <= armed1;
        end
    end

    logic [CNT_W-1:0] cnt_low;
    assign cnt_low = bist_data[CNT_W-1:0];

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!bist_valid && bist_data == '0 && bist_kmask == '0 && !bist_disp_err && !bist_invert)); // R1

    AST_D21_5: assert property (@(posedge clk) disable iff (rst || !armed1)
        ($past(gen_en) && $past(pat_sel) == 2'b00) |-> (bist_valid && bist_data == 32'hB5B5B5B5 && bist_kmask == 4'b0000)); // R2

    AST_D24_3: assert property (@(posedge clk) disable iff (rst || !armed1)
        ($past(gen_en) && $past(pat_sel) == 2'b01) |-> (bist_valid && bist_data == 32'h78787878 && bist_kmask == 4'b0000)); // R3

    AST_MIXED: assert property (@(posedge clk) disable iff (rst || !armed1)
        ($past(gen_en) && $past(pat_sel) == 2'b10) |-> (bist_valid && bist_data == 32'hBC4A4A4A && bist_kmask == 4'b1000)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst || !armed2)
        ($past(gen_en) && $past(pat_sel) == 2'b11 && $past(gen_en, 2) && $past(pat_sel, 2) == 2'b11)
        |-> (cnt_low == CNT_W'($past(cnt_low) + 1'b1) && bist_kmask == 4'b0000)); // R5

    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst || !armed2)
        ($past(gen_en) && $past(pat_sel) == 2'b11 && (!$past(gen_en, 2) || $past(pat_sel, 2) != 2'b11))
        |-> (bist_data == 32'h0)); // R6

    AST_IDLE_WORD: assert property (@(posedge clk) disable iff (rst || !armed1)
        !$past(gen_en) |-> (!bist_valid && bist_data == '0 && bist_kmask == '0)); // R8

    AST_DISP_FORCE: assert property (@(posedge clk) disable iff (rst || !armed1)
        bist_disp_err == ($past(force_disp) && bist_valid)); // R9

    AST_INVERT_FOLLOW: assert property (@(posedge clk) disable iff (rst || !armed1)
        bist_invert == $past(tx_invert)); // R10

endmodule

bind sata_bist_gen sata_bist_gen_chk #(.CNT_W(CNT_W)) i_sata_bist_gen_chk (
    .clk           (clk),
    .rst           (rst),
    .gen_en        (gen_en),
    .pat_sel       (pat_sel),
    .force_disp    (force_disp),
    .tx_invert     (tx_invert),
    .bist_valid    (bist_valid),
    .bist_data     (bist_data),
    .bist_kmask    (bist_kmask),
    .bist_disp_err (bist_disp_err),
    .bist_invert   (bist_invert)
);

// File: tb/test_sata_bist_gen.sv
`timescale 1ns/100ps
module test_sata_bist_gen;

    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_en = 1'b0;
    logic [1:0]  pat_sel = 2'b00;
    logic        force_disp = 1'b0;
    logic        tx_invert = 1'b0;
    logic        bist_valid;
    logic [31:0] bist_data;
    logic [3:0]  bist_kmask;
    logic        bist_disp_err;
    logic        bist_invert;

    always #2.5 clk = ~clk;

    sata_bist_gen #(.CNT_W(CNT_W)) i_sata_bist_gen (
        .clk(clk), .rst(rst), .gen_en(gen_en), .pat_sel(pat_sel),
        .force_disp(force_disp), .tx_invert(tx_invert),
        .bist_valid(bist_valid), .bist_data(bist_data), .bist_kmask(bist_kmask),
        .bist_disp_err(bist_disp_err), .bist_invert(bist_invert)
    );

    typedef struct {
        logic        valid;
        logic [31:0] data;
        logic [3:0]  kmask;
        logic        disp;
        logic        inv;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // reference model state
    logic             m_prev_en  = 1'b0;
    logic [1:0]       m_prev_sel = 2'b00;
    logic [CNT_W-1:0] m_cnt      = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the Dword it must produce
    task automatic drive(input logic en, input logic [1:0] sel,
                         input logic frc, input logic inv);
        exp_t e;
        logic restart;
        logic [CNT_W-1:0] v;
        @(negedge clk);
        gen_en = en; pat_sel = sel; force_disp = frc; tx_invert = inv;
        e.valid = en; e.data = '0; e.kmask = '0; e.disp = en & frc; e.inv = inv;
        e.req = "R8";
        if (en) begin
            case (sel)
                2'b00: begin e.data = 32'hB5B5B5B5; e.req = "R2"; end
                2'b01: begin e.data = 32'h78787878; e.req = "R3"; end
                2'b10: begin e.data = 32'hBC4A4A4A; e.kmask = 4'b1000; e.req = "R4"; end
                default: begin
                    restart = !m_prev_en || (m_prev_sel != sel);
                    v = restart ? '0 : m_cnt;
                    e.data = {{(32-CNT_W){1'b0}}, v};
                    e.req = restart ? "R6" : ((v == '0) ? "R7" : "R5");
                    m_cnt = v + 1'b1;
                end
            endcase
        end
        m_prev_en = en; m_prev_sel = sel;
        exp_q.push_back(e);
    endtask

    // monitor: compare each produced Dword against the queue head
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(bist_valid == e.valid && bist_data == e.data && bist_kmask == e.kmask,
                  e.req, "valid/data/kmask",
                  {27'b0, bist_valid, bist_kmask, bist_data},
                  {27'b0, e.valid, e.kmask, e.data});
            check(bist_disp_err == e.disp, "R9", "disp_err", 64'(bist_disp_err), 64'(e.disp));
            check(bist_invert == e.inv, "R10", "invert", 64'(bist_invert), 64'(e.inv));
        end
    end

    initial begin
        // R1: reset state while inputs request activity
        gen_en = 1'b1; pat_sel = 2'b10; force_disp = 1'b1; tx_invert = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!bist_valid && bist_data == 0 && bist_kmask == 0 && !bist_disp_err && !bist_invert,
              "R1", "reset outputs",
              {59'b0, bist_valid, bist_disp_err, bist_invert, 2'b0} | 64'(bist_data), 64'h0);
        gen_en = 1'b0; force_disp = 1'b0; tx_invert = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        drive(0, 2'b00, 0, 0);
        for (int i = 0; i < 4; i++) drive(1, 2'b00, i[0], 0);   // R2
        for (int i = 0; i < 4; i++) drive(1, 2'b01, 0, i[1]);   // R3
        for (int i = 0; i < 4; i++) drive(1, 2'b10, 1, 1);      // R4
        drive(0, 2'b10, 1, 1);                                  // R8, R9 idle, R10
        drive(0, 2'b11, 0, 0);
        for (int i = 0; i < 10; i++) drive(1, 2'b11, i[2], i[0]); // R5
        drive(0, 2'b11, 0, 1);                                  // R8
        for (int i = 0; i < 5; i++) drive(1, 2'b11, 0, 0);      // R6 after idle
        drive(1, 2'b10, 0, 0);
        for (int i = 0; i < 4; i++) drive(1, 2'b11, 0, 0);      // R6 after select change
        drive(1, 2'b01, 0, 0);
        for (int i = 0; i < 300; i++) drive(1, 2'b11, 0, 0);    // R7 wrap at 255
        drive(0, 2'b00, 0, 0);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule